// File: doc/BRIEF.md
# Dual-Channel Converter Output Pattern Generator

This block sits between the conversion core of a dual-channel 14-bit data converter and its output drivers. On every sample clock it produces one output word per channel. Each channel has its own 3-bit source select. That select either passes the live conversion sample or replaces it with a synthetic word. The synthetic words let a receiver check that it captures the data correctly: all zeros, all ones, a bit-alternating toggle, a wrapping ramp, or a programmable word.

Live samples arrive in offset binary. A 2-bit format field is shared by both channels. Only code 11 keeps offset binary; the other three codes convert to twos complement by inverting the MSB. The format applies to live samples only, and synthetic words leave exactly as defined. The programmable word is shared by both channels and is built from a 6-bit high field and an 8-bit low field. A global digital-enable input gates the whole function. When it is low, raw live samples pass through with no pattern and no format conversion.

Each output is registered, so it shows the result of the inputs present at the previous rising clock edge. The ramp counter and the toggle phase of a channel restart whenever that channel's pattern is not selected, and whenever reset is asserted.

Top module: `adc_tpg`

## Requirements
- R1: While rst_ni is low, both outputs are 0. After reset, each ramp restarts at 0 and each toggle restarts at its first word.
- R2: Each output is registered. The word on a_data_o / b_data_o after a rising edge is computed from the inputs sampled at that edge.
- R3: With the enable high, select 3'b001 drives 14'h0000 and select 3'b010 drives 14'h3FFF.
- R4: With the enable high, select 3'b011 drives 14'h2AAA (binary 10101010101010) on its first clock. After that it alternates every clock with 14'h1555.
- R5: With the enable high, select 3'b100 drives 0 on its first clock and adds 1 every clock. After 16383 it wraps to 0.
- R6: Leaving the toggle or ramp select for at least one clock and then selecting it again restarts that sequence from its first word.
- R7: With the enable high, select 3'b101 drives {cust_hi_i[5:0], cust_lo_i[7:0]}.
- R8: With the enable high, select 3'b000 drives the live sample. If fmt_sel_i is 2'b11, the sample is unchanged. If fmt_sel_i is 2'b00, 2'b01 or 2'b10, bit 13 is inverted.
- R9: With the enable high, the unused selects 3'b110 and 3'b111 behave exactly like 3'b000, including format conversion.
- R10: With dig_en_i low, each output is the raw live sample, whatever the select and format inputs are.
- R11: The two channels are independent. A channel's select, live data and sequence state never affect the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dig_en_i | input | 1 | Global digital-function enable |
| fmt_sel_i | input | 2 | Output format: 11 offset binary, others twos complement |
| cust_hi_i | input | 6 | Programmable word bits 13:8 |
| cust_lo_i | input | 8 | Programmable word bits 7:0 |
| a_pat_sel_i | input | 3 | Channel A source select |
| a_data_i | input | 14 | Channel A live sample, offset binary |
| b_pat_sel_i | input | 3 | Channel B source select |
| b_data_i | input | 14 | Channel B live sample, offset binary |
| a_data_o | output | 14 | Channel A output word |
| b_data_o | output | 14 | Channel B output word |

## Verification
The ramp wrap from 16383 back to 0 is the hardest case to reach. It needs an unbroken run of 16384 clocks with the ramp selected and the enable held high. The stimulus therefore holds channel A on the ramp for a full period plus a few clocks. During that run channel B gets random live data, random selects and random formats, which also exercises channel independence. Restart behaviour is reached by dropping the select or pulsing reset in the middle of a ramp or toggle run. Constrained random traffic with a fixed seed then mixes all selects, formats and enable states.

// File: rtl/adc_tpg_pkg.sv
package adc_tpg_pkg;
  typedef enum logic [2:0] {
    PAT_LIVE   = 3'b000,
    PAT_ZERO   = 3'b001,
    PAT_ONES   = 3'b010,
    PAT_TOGGLE = 3'b011,
    PAT_RAMP   = 3'b100,
    PAT_CUSTOM = 3'b101,
    PAT_RSVD6  = 3'b110,
    PAT_RSVD7  = 3'b111
  } pat_e;

  localparam logic [1:0] FMT_OFFSET_BIN = 2'b11;
endpackage

// File: rtl/tpg_seq.sv
module tpg_seq #(
  parameter int DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ramp_run_i,
  input  logic          tog_run_i,
  output logic [DW-1:0] ramp_o,
  output logic [DW-1:0] tog_o
);
  logic [DW-1:0] ramp_q;
  logic          ph_q;
  logic [DW-1:0] tog_base;

  // natural wrap at 2**DW-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ramp_q <= '0;
    else if (!ramp_run_i) ramp_q <= '0;
    else                 ramp_q <= ramp_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= 1'b0;
    else if (!tog_run_i) ph_q <= 1'b0;
    else                ph_q <= ~ph_q;
  end

  // first word: odd bits set
  for (genvar i = 0; i < DW; i++) begin : g_tog
    assign tog_base[i] = (i % 2) == 1;
  end

  assign ramp_o = ramp_q;
  assign tog_o  = ph_q ? ~tog_base : tog_base;
endmodule

// File: rtl/tpg_fmt.sv
module tpg_fmt #(
  parameter int DW = 14
) (
  input  logic [DW-1:0] live_i,
  input  logic [1:0]    fmt_i,
  output logic [DW-1:0] fmt_o
);
  import adc_tpg_pkg::*;
  logic to_twos;

  assign to_twos = (fmt_i != FMT_OFFSET_BIN);
  assign fmt_o   = {live_i[DW-1] ^ to_twos, live_i[DW-2:0]};
endmodule

// File: rtl/tpg_lane.sv
module tpg_lane #(
  parameter int DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dig_en_i,
  input  logic [2:0]    pat_sel_i,
  input  logic [1:0]    fmt_i,
  input  logic [DW-1:0] live_i,
  input  logic [DW-1:0] cust_i,
  output logic [DW-1:0] data_o
);
  import adc_tpg_pkg::*;

  logic          ramp_run, tog_run;
  logic [DW-1:0] ramp_w, tog_w, live_fmt, nxt;
  logic [DW-1:0] data_q;
  logic          ramp_hist_q, tog_hist_q;

  assign ramp_run = dig_en_i && (pat_sel_i == PAT_RAMP);
  assign tog_run  = dig_en_i && (pat_sel_i == PAT_TOGGLE);

  tpg_seq #(.DW(DW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ramp_run_i(ramp_run),
    .tog_run_i (tog_run),
    .ramp_o    (ramp_w),
    .tog_o     (tog_w)
  );

  tpg_fmt #(.DW(DW)) u_fmt (
    .live_i(live_i),
    .fmt_i (fmt_i),
    .fmt_o (live_fmt)
  );

  always_comb begin
    if (!dig_en_i) begin
      nxt = live_i;
    end else begin
      case (pat_sel_i)
        PAT_ZERO:   nxt = '0;
        PAT_ONES:   nxt = '1;
        PAT_TOGGLE: nxt = tog_w;
        PAT_RAMP:   nxt = ramp_w;
        PAT_CUSTOM: nxt = cust_i;
        default:    nxt = live_fmt;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q      <= '0;
      ramp_hist_q <= 1'b0;
      tog_hist_q  <= 1'b0;
    end else begin
      data_q      <= nxt;
      ramp_hist_q <= ramp_run;
      tog_hist_q  <= tog_run;
    end
  end

  assign data_o = data_q;

  AST_ZERO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_en_i && pat_sel_i == PAT_ZERO) |=> data_o == '0); // R3
  AST_ONES_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_en_i && pat_sel_i == PAT_ONES) |=> data_o == '1); // R3
  AST_TOGGLE_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_run && tog_hist_q) |=> data_o == ~$past(data_o)); // R4
  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_run && ramp_hist_q) |=> data_o == $past(data_o) + 1'b1); // R5
  AST_RAW_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dig_en_i |=> data_o == $past(live_i)); // R10
endmodule

// File: rtl/adc_tpg.sv
module adc_tpg #(
  parameter int DW = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dig_en_i,
  input  logic [1:0]      fmt_sel_i,
  input  logic [DW-9:0]   cust_hi_i,
  input  logic [7:0]      cust_lo_i,
  input  logic [2:0]      a_pat_sel_i,
  input  logic [DW-1:0]   a_data_i,
  input  logic [2:0]      b_pat_sel_i,
  input  logic [DW-1:0]   b_data_i,
  output logic [DW-1:0]   a_data_o,
  output logic [DW-1:0]   b_data_o
);
  localparam int NCH = 2;

  logic [DW-1:0] cust;
  logic [2:0]    sel  [NCH];
  logic [DW-1:0] live [NCH];
  logic [DW-1:0] dout [NCH];

  assign cust    = {cust_hi_i, cust_lo_i};
  assign sel[0]  = a_pat_sel_i;
  assign sel[1]  = b_pat_sel_i;
  assign live[0] = a_data_i;
  assign live[1] = b_data_i;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    tpg_lane #(.DW(DW)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dig_en_i (dig_en_i),
      .pat_sel_i(sel[c]),
      .fmt_i    (fmt_sel_i),
      .live_i   (live[c]),
      .cust_i   (cust),
      .data_o   (dout[c])
    );
  end

  assign a_data_o = dout[0];
  assign b_data_o = dout[1];

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (a_data_o == '0 && b_data_o == '0)); // R1
endmodule

// File: tb/sim_adc_tpg.sv
`timescale 1ns/1ps
module sim_adc_tpg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dig_en_i = 1'b0;
  logic [1:0]  fmt_sel_i = 2'b11;
  logic [5:0]  cust_hi_i = '0;
  logic [7:0]  cust_lo_i = '0;
  logic [2:0]  a_pat_sel_i = '0, b_pat_sel_i = '0;
  logic [13:0] a_data_i = '0, b_data_i = '0;
  logic [13:0] a_data_o, b_data_o;

  int n_cmp = 0, n_bad = 0;
  logic [13:0] ramp_m [2];
  logic        ph_m   [2];

  always #10 clk_i = ~clk_i;

  adc_tpg u0 (
    .clk_i, .rst_ni, .dig_en_i, .fmt_sel_i, .cust_hi_i, .cust_lo_i,
    .a_pat_sel_i, .a_data_i, .b_pat_sel_i, .b_data_i, .a_data_o, .b_data_o
  );

  function automatic logic [13:0] exp_word(logic en, logic [2:0] sel, logic [1:0] fmt,
      logic [13:0] live, logic [13:0] cust, logic [13:0] ramp, logic ph);
    if (!en) return live;
    case (sel)
      3'b001: return 14'h0000;
      3'b010: return 14'h3FFF;
      3'b011: return ph ? 14'h1555 : 14'h2AAA;
      3'b100: return ramp;
      3'b101: return cust;
      default: return (fmt == 2'b11) ? live : (live ^ 14'h2000);
    endcase
  endfunction

  function automatic string req_of(logic en, logic [2:0] sel);
    if (!en) return "R10";
    case (sel)
      3'b000: return "R8";
      3'b001, 3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic cmp(string req, logic [13:0] act, logic [13:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs already set; one clock, then compare both channels (R2, R11)
  task automatic step(string extra);
    logic [13:0] ea, eb;
    ea = exp_word(dig_en_i, a_pat_sel_i, fmt_sel_i, a_data_i, {cust_hi_i, cust_lo_i}, ramp_m[0], ph_m[0]);
    eb = exp_word(dig_en_i, b_pat_sel_i, fmt_sel_i, b_data_i, {cust_hi_i, cust_lo_i}, ramp_m[1], ph_m[1]);
    ramp_m[0] = (dig_en_i && a_pat_sel_i == 3'b100) ? ramp_m[0] + 14'd1 : 14'd0;
    ramp_m[1] = (dig_en_i && b_pat_sel_i == 3'b100) ? ramp_m[1] + 14'd1 : 14'd0;
    ph_m[0]   = (dig_en_i && a_pat_sel_i == 3'b011) ? ~ph_m[0] : 1'b0;
    ph_m[1]   = (dig_en_i && b_pat_sel_i == 3'b011) ? ~ph_m[1] : 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    cmp({req_of(dig_en_i, a_pat_sel_i), "/A R2 ", extra}, a_data_o, ea);
    cmp({req_of(dig_en_i, b_pat_sel_i), "/B R11 ", extra}, b_data_o, eb);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    cmp("R1 reset A", a_data_o, 14'h0);
    cmp("R1 reset B", b_data_o, 14'h0);
    ramp_m[0] = 0; ramp_m[1] = 0; ph_m[0] = 0; ph_m[1] = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ramp_m[0] = 0; ramp_m[1] = 0; ph_m[0] = 0; ph_m[1] = 0;
    #5;
    cmp("R1 reset A", a_data_o, 14'h0);
    cmp("R1 reset B", b_data_o, 14'h0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 disabled: raw pass with every select
    dig_en_i = 0;
    for (int s = 0; s < 8; s++) begin
      a_pat_sel_i = 3'(s); b_pat_sel_i = 3'(7 - s); fmt_sel_i = 2'(s);
      a_data_i = 14'($urandom); b_data_i = 14'($urandom);
      step("R10 disabled");
    end

    // R8 live with each format
    dig_en_i = 1; a_pat_sel_i = 0; b_pat_sel_i = 0;
    for (int f = 0; f < 4; f++) begin
      fmt_sel_i = 2'(f);
      a_data_i = 14'h2000; b_data_i = 14'h1FFF;
      step("R8 format");
    end

    // R3, R7, R9
    a_pat_sel_i = 3'b001; b_pat_sel_i = 3'b010; step("R3");
    cust_hi_i = 6'h2D; cust_lo_i = 8'hC3;
    a_pat_sel_i = 3'b101; b_pat_sel_i = 3'b110; fmt_sel_i = 2'b01; step("R7 R9");
    a_pat_sel_i = 3'b111; b_pat_sel_i = 3'b101; fmt_sel_i = 2'b11; step("R9 R7");

    // R4 toggle, then R6 restart
    a_pat_sel_i = 3'b011; b_pat_sel_i = 3'b000;
    for (int i = 0; i < 5; i++) step("R4");
    a_pat_sel_i = 3'b000; step("R6 leave");
    a_pat_sel_i = 3'b011; step("R6 toggle restart");
    step("R4");

    // R5 full ramp wrap on A; B random (R11)
    a_pat_sel_i = 3'b100;
    for (int i = 0; i < 16390; i++) begin
      b_pat_sel_i = 3'($urandom); fmt_sel_i = 2'($urandom);
      b_data_i = 14'($urandom); a_data_i = 14'($urandom);
      step("R5 wrap R11");
    end
    b_pat_sel_i = 3'b100;
    for (int i = 0; i < 20; i++) step("R5");
    // R6 restart via deselect, R1 restart via reset
    a_pat_sel_i = 3'b001; step("R6 leave");
    a_pat_sel_i = 3'b100; step("R6 ramp restart");
    step("R5");
    do_reset();
    step("R1 ramp restart after reset");
    step("R5");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      dig_en_i = ($urandom % 8) != 0;
      a_pat_sel_i = ($urandom % 3 == 0) ? 3'($urandom) : a_pat_sel_i;
      b_pat_sel_i = ($urandom % 3 == 0) ? 3'($urandom) : b_pat_sel_i;
      fmt_sel_i = 2'($urandom);
      cust_hi_i = 6'($urandom); cust_lo_i = 8'($urandom);
      a_data_i = 14'($urandom); b_data_i = 14'($urandom);
      step("random");
      if (i == 2000) do_reset();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule